// File: doc/BRIEF.md
# Codec Serial Frame Engine

This block drives a continuous full-duplex serial link to an external audio and telecom codec. While its enable input is high, it generates a serial clock from the system clock through an integer divider. It marks each frame with a one-period sync pulse, shifts a parallel transmit word out MSB first and assembles a parallel receive word from the data input. Frames follow one another with no idle time. The transmit source sees a one-cycle load strobe each time a word is taken. The receive side sees a one-cycle valid strobe each time a full word has arrived.

Clearing the enable stops the link at the next system clock edge. The frame in progress is dropped, and a one-cycle flush strobe goes to the surrounding FIFOs. The last received word stays on its output. The block also decides who owns a set of pins that it shares with a second synchronous serial port. This port takes precedence. The other port may run at the same time only when a reassignment input has moved it to other pins. When neither port needs the shared pins, they are handed back to general-purpose I/O.

Top module: `codec_frame_engine`

## Requirements
- R1: After a synchronous reset, sclk, sfrm, txd, tx_load, rx_valid, fifo_flush and own_pins are all 0, and rx_word is 0.
- R2: While port_en is high, sclk toggles every CLK_HALF system cycles. While port_en is low, sclk stays at 0.
- R3: The first sclk rising edge after enable comes CLK_HALF system edges after the edge that first samples port_en high. sfrm goes high on that rising edge and stays high for exactly one sclk period (2*CLK_HALF system cycles).
- R4: sfrm rises only on a system edge where sclk also rises. Successive sfrm rising edges are exactly FRAME_BITS sclk periods (2*CLK_HALF*FRAME_BITS system cycles) apart, so there is no gap between frames.
- R5: tx_word is sampled on the system edge where sfrm rises. tx_load is high for that one cycle only. The sampled word appears on txd MSB first, one bit per sclk period, with each bit changing on an sclk rising edge.
- R6: rxd is sampled on each sclk falling edge, and the first bit of a frame is the MSB. After the FRAME_BITS-th falling edge of a frame, rx_word holds the received word and rx_valid is high for exactly one cycle.
- R7: When port_en is sampled low, sclk, sfrm and txd are 0 from the next edge on, and the abandoned frame produces no rx_valid.
- R8: fifo_flush is high for exactly one cycle, namely the cycle right after the edge that first samples port_en low after it was high. It is 0 at all other times.
- R9: rx_word changes only together with rx_valid. Disabling the port keeps its value.
- R10: own_pins equals port_en. other_run is high when other_en is high and either port_en is low or remap is high.
- R11: shared_gpio is high when port_en is low and either other_en is low or remap is high.
- R12: After a re-enable, the link starts again from bit 0 of a new frame, with the same enable-to-sync delay as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Enable bit of this port |
| other_en | input | 1 | Enable request of the second serial port |
| remap | input | 1 | Moves the second port away from the shared pins |
| tx_word | input | FRAME_BITS | Next transmit frame |
| tx_load | output | 1 | Pulse: tx_word has been taken |
| rx_word | output | FRAME_BITS | Last complete received frame |
| rx_valid | output | 1 | Pulse: rx_word has just been updated |
| sclk | output | 1 | Serial clock |
| sfrm | output | 1 | Frame sync |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |
| fifo_flush | output | 1 | One-cycle FIFO reset on disable |
| own_pins | output | 1 | This port drives the shared pins |
| other_run | output | 1 | The second port may operate |
| shared_gpio | output | 1 | Shared pins return to general-purpose I/O |

## Verification
The assertions assume that port_en, other_en, remap and rxd are synchronous to clk and change only between edges. They also assume that tx_word is held from one tx_load strobe to the next. The bench changes every input one time unit after a rising edge. It changes rxd only on the cycle where sclk has just risen, which keeps rxd stable over the following falling edge. It moves to the next transmit word only after it sees the load strobe.

// File: rtl/cfe_pkg.sv
package cfe_pkg;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_RISE = 2'd1,
        EV_FALL = 2'd2
    } sclk_ev_e;

    typedef struct packed {
        logic own;
        logic other_run;
        logic gpio;
    } pin_own_s;

    function automatic pin_own_s arbitrate(input logic me, input logic other, input logic moved);
        pin_own_s r;
        r.own       = me;
        r.other_run = other & (~me | moved);
        r.gpio      = ~me & (~other | moved);
        return r;
    endfunction

endpackage

// File: rtl/cfe_sclk_gen.sv
module cfe_sclk_gen
    import cfe_pkg::*;
#(
    parameter int CLK_HALF = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    output logic     sclk,
    output sclk_ev_e ev
);
    localparam int CW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;

    logic [CW-1:0] cnt;
    logic          term;

    assign term = (cnt == CW'(CLK_HALF - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (term) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    always_comb begin
        ev = EV_NONE;
        if (run && term) begin
            ev = sclk ? EV_FALL : EV_RISE;
        end
    end

    // R2: clock parked low once the port is off
    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !run |=> !sclk);

endmodule

// File: rtl/cfe_framer.sv
module cfe_framer
    import cfe_pkg::*;
#(
    parameter int FRAME_BITS = 128
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run,
    input  sclk_ev_e              ev,
    input  logic [FRAME_BITS-1:0] tx_word,
    input  logic                  rxd,
    output logic                  sfrm,
    output logic                  txd,
    output logic                  tx_load,
    output logic [FRAME_BITS-1:0] rx_word,
    output logic                  rx_valid
);
    localparam int BW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;

    logic [BW-1:0]         bit_cnt;
    logic [FRAME_BITS-1:0] tx_sh;
    logic [FRAME_BITS-1:0] rx_sh;
    logic                  last_bit;
    logic                  first_bit;

    assign last_bit  = (bit_cnt == BW'(FRAME_BITS - 1));
    assign first_bit = (bit_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt  <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            sfrm     <= 1'b0;
            txd      <= 1'b0;
            tx_load  <= 1'b0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            tx_load  <= 1'b0;
            rx_valid <= 1'b0;
            if (!run) begin
                bit_cnt <= '0;
                tx_sh   <= '0;
                rx_sh   <= '0;
                sfrm    <= 1'b0;
                txd     <= 1'b0;
            end else begin
                case (ev)
                    EV_RISE: begin
                        if (first_bit) begin
                            sfrm    <= 1'b1;
                            tx_load <= 1'b1;
                            txd     <= tx_word[FRAME_BITS-1];
                            tx_sh   <= tx_word << 1;
                        end else begin
                            sfrm    <= 1'b0;
                            txd     <= tx_sh[FRAME_BITS-1];
                            tx_sh   <= tx_sh << 1;
                        end
                    end
                    EV_FALL: begin
                        rx_sh <= {rx_sh[FRAME_BITS-2:0], rxd};
                        if (last_bit) begin
                            bit_cnt  <= '0;
                            rx_word  <= {rx_sh[FRAME_BITS-2:0], rxd};
                            rx_valid <= 1'b1;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R6: valid strobe lasts a single cycle
    p_rxv_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R9: received word only moves with its strobe
    p_rxword_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> (rx_valid || $stable(rx_word)));

endmodule

// File: rtl/cfe_pin_arb.sv
module cfe_pin_arb
    import cfe_pkg::*;
(
    input  logic     me_en,
    input  logic     other_en,
    input  logic     moved,
    output pin_own_s pins
);
    assign pins = arbitrate(me_en, other_en, moved);
endmodule

// File: rtl/codec_frame_engine.sv
module codec_frame_engine
    import cfe_pkg::*;
#(
    parameter int FRAME_BITS = 128,
    parameter int CLK_HALF   = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  port_en,
    input  logic                  other_en,
    input  logic                  remap,
    input  logic [FRAME_BITS-1:0] tx_word,
    output logic                  tx_load,
    output logic [FRAME_BITS-1:0] rx_word,
    output logic                  rx_valid,
    output logic                  sclk,
    output logic                  sfrm,
    output logic                  txd,
    input  logic                  rxd,
    output logic                  fifo_flush,
    output logic                  own_pins,
    output logic                  other_run,
    output logic                  shared_gpio
);
    sclk_ev_e ev;
    pin_own_s pins;
    logic     en_q;

    cfe_sclk_gen #(.CLK_HALF(CLK_HALF)) u_sclk (
        .clk (clk),
        .rst (rst),
        .run (port_en),
        .sclk(sclk),
        .ev  (ev)
    );

    cfe_framer #(.FRAME_BITS(FRAME_BITS)) u_frm (
        .clk     (clk),
        .rst     (rst),
        .run     (port_en),
        .ev      (ev),
        .tx_word (tx_word),
        .rxd     (rxd),
        .sfrm    (sfrm),
        .txd     (txd),
        .tx_load (tx_load),
        .rx_word (rx_word),
        .rx_valid(rx_valid)
    );

    cfe_pin_arb u_arb (
        .me_en   (port_en),
        .other_en(other_en),
        .moved   (remap),
        .pins    (pins)
    );

    assign own_pins    = pins.own;
    assign other_run   = pins.other_run;
    assign shared_gpio = pins.gpio;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= 1'b0;
            fifo_flush <= 1'b0;
        end else begin
            en_q       <= port_en;
            fifo_flush <= en_q & ~port_en;
        end
    end

    // R7: disable silences the pins on the next edge
    p_abort_r7: assert property (@(posedge clk) disable iff (rst)
        !port_en |=> (!sclk && !sfrm && !txd && !rx_valid));

    // R8: flush is a single-cycle strobe
    p_flush_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        fifo_flush |=> !fifo_flush);

    // R4: frame sync rises together with the serial clock
    p_sync_align_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sfrm) |-> $rose(sclk));

    // R5: word taken only at a frame start
    p_load_at_sync_r5: assert property (@(posedge clk) disable iff (rst)
        tx_load |-> ($rose(sfrm) && sclk));

endmodule

// File: tb/sim_codec_frame_engine.sv
`timescale 1ns/1ps
module sim_codec_frame_engine;
    localparam int N    = 16;
    localparam int HALF = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         port_en = 1'b0;
    logic         other_en = 1'b0;
    logic         remap = 1'b0;
    logic [N-1:0] tx_word;
    logic         tx_load;
    logic [N-1:0] rx_word;
    logic         rx_valid;
    logic         sclk, sfrm, txd;
    logic         rxd = 1'b0;
    logic         fifo_flush, own_pins, other_run, shared_gpio;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [N-1:0] rxp(input int k);
        case (k % 4)
            0: return '1;
            1: return N'(16'hA5C3) ^ N'(k * 16'h1357);
            2: return N'(16'h8001) ^ N'(k);
            default: return N'(16'h3C96) ^ N'(k * 7);
        endcase
    endfunction

    function automatic logic [N-1:0] txp(input int k);
        return ~rxp(k + 1) ^ N'(k << 3);
    endfunction

    int tx_idx = 0;
    assign tx_word = txp(tx_idx);

    codec_frame_engine #(.FRAME_BITS(N), .CLK_HALF(HALF)) u0 (
        .clk(clk), .rst(rst), .port_en(port_en), .other_en(other_en), .remap(remap),
        .tx_word(tx_word), .tx_load(tx_load), .rx_word(rx_word), .rx_valid(rx_valid),
        .sclk(sclk), .sfrm(sfrm), .txd(txd), .rxd(rxd), .fifo_flush(fifo_flush),
        .own_pins(own_pins), .other_run(other_run), .shared_gpio(shared_gpio)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: runs on falling system edges, away from DUT updates.
    int           cyc = 0;
    int           idx = 0;
    int           last_rise = -1;
    int           last_tog = -1;
    int           rx_fr = 0;
    int           rx_frames = 0;
    logic         sclk_p = 1'b0, sfrm_p = 1'b0, rxv_p = 1'b0;
    logic [N-1:0] exp_tx = '0;
    logic [N-1:0] last_rx_exp = '0;

    always @(negedge clk) begin
        logic [N-1:0] rpat;
        bit           sync_rise;
        cyc++;
        if (rst || !port_en) begin
            idx = 0; last_rise = -1; last_tog = -1;
            sclk_p = 1'b0; sfrm_p = 1'b0; rxv_p = 1'b0;
        end else begin
            sync_rise = sfrm && !sfrm_p;
            if (sclk != sclk_p) begin
                if (last_tog >= 0) chk(cyc - last_tog == HALF, "R2 sclk half period", 64'(cyc - last_tog), 64'(HALF));
                last_tog = cyc;
            end
            if (tx_load != sync_rise) chk(0, "R5 tx_load with sync", 64'(tx_load), 64'(sync_rise));
            if (sync_rise) begin
                chk(sclk && !sclk_p, "R4 sync on sclk rise", 64'(sclk), 64'd1);
                if (last_rise >= 0) chk(cyc - last_rise == 2*HALF*N, "R4 frame spacing", 64'(cyc - last_rise), 64'(2*HALF*N));
                last_rise = cyc;
                exp_tx = tx_word;
                tx_idx++;
                idx = 0;
            end
            if (!sfrm && sfrm_p)
                chk(cyc - last_rise == 2*HALF, "R3 sync width", 64'(cyc - last_rise), 64'(2*HALF));
            if (sclk && !sclk_p && idx < N) begin
                chk(txd == exp_tx[N-1-idx], "R5 txd bit", 64'(txd), 64'(exp_tx[N-1-idx]));
                rpat = rxp(rx_fr);
                rxd = rpat[N-1-idx];
                idx++;
            end
            if (rx_valid) begin
                chk(!rxv_p, "R6 valid width", 64'(rxv_p), 64'd0);
                chk(rx_word == rxp(rx_fr), "R6 rx word", 64'(rx_word), 64'(rxp(rx_fr)));
                last_rx_exp = rxp(rx_fr);
                rx_fr++;
                rx_frames++;
            end
            sclk_p = sclk; sfrm_p = sfrm; rxv_p = rx_valid;
        end
    end

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    initial begin
        int n;
        int f0;
        repeat (3) tick();
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!sclk && !sfrm && !txd, "R1 serial pins idle", {sclk, sfrm, txd}, 0);
        chk(!tx_load && !rx_valid && !fifo_flush, "R1 strobes idle", {tx_load, rx_valid, fifo_flush}, 0);
        chk(rx_word == '0 && !own_pins, "R1 rx_word/own", {own_pins, rx_word}, 0);

        // R10/R11 sweep over all input combinations (port_en alternates)
        for (int m = 0; m < 8; m++) begin
            bit me, ot, mv;
            tick();
            me = m[0]; ot = m[1]; mv = m[2];
            port_en = me; other_en = ot; remap = mv;
            @(negedge clk);
            chk(own_pins == me, "R10 own_pins", 64'(own_pins), 64'(me));
            chk(other_run == (ot && (!me || mv)), "R10 other_run", 64'(other_run), 64'(ot && (!me || mv)));
            chk(shared_gpio == (!me && (!ot || mv)), "R11 shared_gpio", 64'(shared_gpio), 64'(!me && (!ot || mv)));
        end
        tick();
        port_en = 1'b0; other_en = 1'b0; remap = 1'b0;
        repeat (6) tick();
        chk(!fifo_flush && !sclk, "R8 flush quiet while idle", {fifo_flush, sclk}, 0);

        // R3 first sync delay
        tick();
        port_en = 1'b1;
        n = 0;
        do begin tick(); n++; end while (!sfrm && n < 50);
        chk(n == HALF, "R3 enable to first sync", 64'(n), 64'(HALF));

        while (rx_frames < 5) @(negedge clk);
        while (idx != 5) @(negedge clk);

        // R7/R8/R9 abort mid-frame
        f0 = rx_frames;
        tick();
        port_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!sclk && !sfrm && !txd, "R7 pins stopped", {sclk, sfrm, txd}, 0);
        chk(fifo_flush, "R8 flush pulse", 64'(fifo_flush), 64'd1);
        chk(rx_word == last_rx_exp, "R9 rx_word kept", 64'(rx_word), 64'(last_rx_exp));
        @(negedge clk);
        chk(!fifo_flush, "R8 flush single cycle", 64'(fifo_flush), 64'd0);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (sclk || rx_valid || fifo_flush)
                chk(0, "R7 idle after abort", {sclk, rx_valid, fifo_flush}, 0);
        end
        chk(rx_frames == f0 && rx_word == last_rx_exp, "R9 no rx after abort", 64'(rx_word), 64'(last_rx_exp));

        // R12 restart from bit 0
        tick();
        port_en = 1'b1;
        n = 0;
        do begin tick(); n++; end while (!sfrm && n < 50);
        chk(n == HALF, "R12 restart sync delay", 64'(n), 64'(HALF));
        while (rx_frames < f0 + 2) @(negedge clk);
        chk(rx_word == last_rx_exp, "R12 first frames after restart", 64'(rx_word), 64'(last_rx_exp));
        tick();
        port_en = 1'b0;
        repeat (4) tick();

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule